// File: doc/BRIEF.md
# System Tick Timer

This block is a periodic down-counter with a small word-addressed register bus. Software loads a 24-bit reload value, selects whether the counter steps on every processor clock or on rising edges of a slower external reference signal, and enables it. Each time the count steps from 1 to 0 the block sets a sticky wrap flag and, if interrupts are enabled, pulses an interrupt request for one clock. The counter then reloads from the reload register on its next step. A reload value of N therefore gives one event every N+1 counting steps.

Four 32-bit registers sit at byte offsets 0x0 (control/status), 0x4 (reload), 0x8 (current value) and 0xC (calibration, read-only). Read data is registered and appears one clock after the read strobe. A read of the control/status register clears the wrap flag. Any write to the current-value register zeroes the counter and the flag. Calibration contents and the absence of a reference input are fixed by parameters. When no reference exists, the clock-source bit always reads 1.

Top module: `systick_timer`

## Requirements
- R1: Registers decode on address bits [3:2]: word 0 is control/status, word 1 is reload, word 2 is current value and word 3 is calibration. `bus_rdata` shows the addressed register on the clock after a cycle with `bus_rd` high. Undefined bits read as zero.
- R2: The reload register stores write-data bits [23:0]. Bits [31:24] of the reload and current-value registers read as zero.
- R3: With a reload of N (1 to 0xFFFFFF), the wrap event occurs when the counter steps from 1 to 0. Events repeat every N+1 counting steps, because a step taken at zero loads the reload value.
- R4: With the interrupt-enable bit (control bit 1) set, `tick_irq` is high for exactly one clock per wrap event. With it clear, `tick_irq` stays low.
- R5: The wrap flag (control bit 16) is set by a wrap event. It stays set until a read of the control/status register, which returns it as 1 and clears it. A wrap in the same cycle as the read leaves it set.
- R6: While the enable bit (control bit 0) is 0, the counter holds its value.
- R7: Any write to the current-value register sets the counter to zero and clears the wrap flag, whatever data is written.
- R8: With the clock-source bit (control bit 2) at 1, the counter steps on every clock. At 0, it steps once per rising edge of `ref_in`, after a two-flop synchronizer and edge detector. If `ref_in` does not toggle, the counter does not step.
- R9: When parameter NO_REF is 1, the clock-source bit reads as 1 and writes to it are ignored, so counting uses the processor clock.
- R10: The calibration register returns NO_REF at bit 31, SKEW at bit 30 and the 24-bit TENMS parameter at bits [23:0]. Bits [29:24] read as zero, and writes do not change it.
- R11: After reset, enable, interrupt enable, the wrap flag, the reload value and the counter are 0. The clock-source bit is NO_REF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| ref_in | input | 1 | Asynchronous external reference signal |
| tick_irq | output | 1 | One-clock interrupt request per wrap |

## Verification
The period is measured in processor-clock mode with reloads of 4 and 1. The value 1 is the shortest legal period, and it distinguishes a reload taken at zero from an event raised on the reload step itself. Reference mode is tried with `ref_in` toggling slowly and with `ref_in` held still. Together these separate stepping on synchronized rising edges from stepping on every clock or on both edges. Flag patterns cover a double read with the counter stopped, a wrap with interrupts masked, and a clearing write to the current-value register. These show the flag is sticky, cleared by a read, and independent of the interrupt enable. A second instance with no reference checks that the clock-source bit cannot be cleared.

// File: rtl/systick_pkg.sv
package systick_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 24;
  localparam int ADDR_W  = 4;

  // word index decoded from address bits [3:2]
  localparam logic [1:0] WORD_CTRL  = 2'd0;
  localparam logic [1:0] WORD_LOAD  = 2'd1;
  localparam logic [1:0] WORD_CUR   = 2'd2;
  localparam logic [1:0] WORD_CALIB = 2'd3;

  // control/status bit positions
  localparam int BIT_EN    = 0;
  localparam int BIT_IE    = 1;
  localparam int BIT_SRC   = 2;
  localparam int BIT_FLAG  = 16;
  // calibration bit positions
  localparam int BIT_NOREF = 31;
  localparam int BIT_SKEW  = 30;
endpackage

// File: rtl/systick_refsync.sv
module systick_refsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic ref_tick
);
  // STAGES synchronizer flops plus one history flop for edge detection
  localparam int LEN = STAGES + 1;
  logic [LEN-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[LEN-2:0], ref_in};
  end

  assign ref_tick = chain[LEN-2] & ~chain[LEN-1];

  // an edge detector never yields two ticks back to back
  assert_tick_single_R8: assert property (@(posedge clk) disable iff (rst)
    ref_tick |=> !ref_tick);
endmodule

// File: rtl/systick_counter.sv
module systick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             step,
  input  logic             clr,
  input  logic             irq_en,
  input  logic             flag_rdclr,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             flag;
  logic             irq;
  logic             adv;
  logic             wrap;

  assign adv  = enable && step;
  assign wrap = adv && (cnt == ONE) && !clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= (cnt == '0) ? reload : cnt - ONE;
    end
  end

  // set wins over read-clear so no wrap is lost
  always_ff @(posedge clk) begin
    if (rst)             flag <= 1'b0;
    else if (clr)        flag <= 1'b0;
    else if (wrap)       flag <= 1'b1;
    else if (flag_rdclr) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= wrap && irq_en;
  end

  assign cnt_o  = cnt;
  assign flag_o = flag;
  assign irq_o  = irq;

  assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (rst)
    (!enable && !clr) |=> $stable(cnt));
  assert_clear_write_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0 && !flag));
  assert_irq_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
    irq |-> (cnt == '0 && flag));
  assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  assert_irq_masked_R4: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);
endmodule

// File: rtl/systick_regs.sv
module systick_regs
  import systick_pkg::*;
#(
  parameter bit          NO_REF = 1'b0,
  parameter bit          SKEW   = 1'b1,
  parameter logic [23:0] TENMS  = 24'd12345
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output logic              en,
  output logic              irq_en,
  output logic              src,
  output logic [CNT_W-1:0]  reload,
  output logic              cur_clr,
  output logic              flag_rdclr
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [1:0]        word;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] calib_word;

  assign word = bus_addr[3:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      irq_en <= 1'b0;
      src    <= NO_REF;
      reload <= '0;
    end else if (bus_wr) begin
      if (word == WORD_CTRL) begin
        en     <= bus_wdata[BIT_EN];
        irq_en <= bus_wdata[BIT_IE];
        src    <= NO_REF ? 1'b1 : bus_wdata[BIT_SRC];
      end
      if (word == WORD_LOAD) reload <= bus_wdata[CNT_W-1:0];
    end
  end

  assign cur_clr    = bus_wr && (word == WORD_CUR);
  assign flag_rdclr = bus_rd && (word == WORD_CTRL);

  always_comb begin
    calib_word             = '0;
    calib_word[BIT_NOREF]  = NO_REF;
    calib_word[BIT_SKEW]   = SKEW;
    calib_word[CNT_W-1:0]  = TENMS;
  end

  always_comb begin
    rd_mux = '0;
    unique case (word)
      WORD_CTRL: begin
        rd_mux[BIT_EN]   = en;
        rd_mux[BIT_IE]   = irq_en;
        rd_mux[BIT_SRC]  = src;
        rd_mux[BIT_FLAG] = flag;
      end
      WORD_LOAD:  rd_mux = {{PAD_W{1'b0}}, reload};
      WORD_CUR:   rd_mux = {{PAD_W{1'b0}}, cnt};
      WORD_CALIB: rd_mux = calib_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_noref_src_R9: assert property (@(posedge clk) disable iff (rst)
    (NO_REF && bus_rd && word == WORD_CTRL) |=> bus_rdata[BIT_SRC]);
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (word == WORD_LOAD || word == WORD_CUR)) |=>
      (bus_rdata[DATA_W-1:CNT_W] == '0));
endmodule

// File: rtl/systick_timer.sv
module systick_timer
  import systick_pkg::*;
#(
  parameter bit          NO_REF      = 1'b0,
  parameter bit          SKEW        = 1'b1,
  parameter logic [23:0] TENMS       = 24'd12345,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ref_in,
  output logic              tick_irq
);
  logic             en, irq_en, src, cur_clr, flag_rdclr, flag, ref_tick, step;
  logic [CNT_W-1:0] reload, cnt;

  generate
    if (NO_REF) begin : g_noref
      assign ref_tick = 1'b0;
    end else begin : g_ref
      systick_refsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ref_in(ref_in), .ref_tick(ref_tick));
    end
  endgenerate

  assign step = src ? 1'b1 : ref_tick;

  systick_regs #(.NO_REF(NO_REF), .SKEW(SKEW), .TENMS(TENMS)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cnt(cnt), .flag(flag), .en(en), .irq_en(irq_en), .src(src),
    .reload(reload), .cur_clr(cur_clr), .flag_rdclr(flag_rdclr));

  systick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .enable(en), .step(step), .clr(cur_clr),
    .irq_en(irq_en), .flag_rdclr(flag_rdclr), .reload(reload),
    .cnt_o(cnt), .flag_o(flag), .irq_o(tick_irq));
endmodule

// File: tb/tb_systick_timer.sv
module tb_systick_timer;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0, addr2 = '0;
  logic        wr = 0, rd = 0, wr2 = 0, rd2 = 0;
  logic [31:0] wdata = '0, wdata2 = '0;
  logic [31:0] rdata, rdata2;
  logic        ref_sig = 0, ref_run = 0;
  logic        irq, irq2;
  logic        rd_q = 0;
  logic [31:0] last_rdata = '0;
  int          checks = 0, fails = 0;
  item_t       sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  systick_timer dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(rdata), .ref_in(ref_sig), .tick_irq(irq));

  systick_timer #(.NO_REF(1'b1), .SKEW(1'b0), .TENMS(24'd0)) dut2 (
    .clk(clk), .rst(rst), .bus_addr(addr2), .bus_wr(wr2), .bus_wdata(wdata2),
    .bus_rd(rd2), .bus_rdata(rdata2), .ref_in(1'b0), .tick_irq(irq2));

  // reference generator: toggles every 4 clocks while running
  initial begin
    forever begin
      repeat (4) @(negedge clk);
      if (ref_run) ref_sig = ~ref_sig;
    end
  end

  // monitor: pops the scoreboard one clock after each read strobe
  always @(posedge clk) rd_q <= rd;
  always @(negedge clk) begin
    if (rd_q) begin
      last_rdata = rdata;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        if (it.mask != 0) begin
          checks++;
          if ((rdata & it.mask) !== (it.exp & it.mask)) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", it.tag, rdata & it.mask, it.exp & it.mask);
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [31:0] e,
                          input logic [31:0] m, input string tag);
    item_t it;
    it.exp = e; it.mask = m; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0;
    #1;
  endtask

  task automatic bus_write2(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr2 = a; wdata2 = d; wr2 = 1;
    @(negedge clk); wr2 = 0;
  endtask

  task automatic bus_read2(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); addr2 = a; rd2 = 1;
    @(negedge clk); rd2 = 0; v = rdata2;
  endtask

  // cycles between two consecutive irq pulses of the selected instance
  task automatic measure(input bit which, output int gap);
    int n = 0;
    do begin @(negedge clk); n++; end while (!(which ? irq2 : irq) && n < 400);
    n = 0;
    do begin @(negedge clk); n++; end while (!(which ? irq2 : irq) && n < 400);
    gap = n;
  endtask

  task automatic count_irq(input int cycles, output int pulses);
    pulses = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (irq) pulses++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int gap, pulses;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;

    // R11 reset state, R1 map, R10 calibration
    bus_read(4'h0, 32'h0, 32'hFFFF_FFFF, "R11 ctrl reset");
    bus_read(4'h4, 32'h0, 32'hFFFF_FFFF, "R11 reload reset");
    bus_read(4'h8, 32'h0, 32'hFFFF_FFFF, "R11 current reset");
    bus_read(4'hC, 32'h4000_3039, 32'hFFFF_FFFF, "R10 calib");
    bus_write(4'hC, 32'hFFFF_FFFF);
    bus_read(4'hC, 32'h4000_3039, 32'hFFFF_FFFF, "R10 calib after write");

    // R2 reload width
    bus_write(4'h4, 32'hAB12_3456);
    bus_read(4'h4, 32'h0012_3456, 32'hFFFF_FFFF, "R2 reload upper zero");

    // R3/R4 processor clock, reload 4 -> period 5
    bus_write(4'h4, 32'd4);
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, 32'h7);
    measure(0, gap);
    check(gap == 5, "R3 period reload 4", gap, 5);
    bus_read(4'h8, 32'h0, 32'hFF00_0000, "R2 current upper zero");

    // R5 flag sticky, cleared by read; stop counter first
    bus_write(4'h0, 32'h6);
    bus_read(4'h0, 32'h0001_0006, 32'hFFFF_FFFF, "R5 flag set");
    bus_read(4'h0, 32'h0000_0006, 32'hFFFF_FFFF, "R5 flag cleared by read");

    // R6 hold while disabled
    bus_read(4'h8, 32'h0, 32'h0, "R6 sample");
    v = last_rdata;
    repeat (10) @(negedge clk);
    bus_read(4'h8, v, 32'hFFFF_FFFF, "R6 hold");

    // R3 shortest period, reload 1 -> period 2
    bus_write(4'h4, 32'd1);
    bus_write(4'h0, 32'h7);
    measure(0, gap);
    check(gap == 2, "R3 period reload 1", gap, 2);

    // R4 masked interrupt still sets flag
    bus_write(4'h4, 32'd3);
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, 32'h5);
    count_irq(30, pulses);
    check(pulses == 0, "R4 masked irq", pulses, 0);
    bus_write(4'h0, 32'h4);
    bus_read(4'h0, 32'h0001_0004, 32'hFFFF_FFFF, "R4 flag while masked");

    // R7 write to current clears counter and flag
    bus_write(4'h0, 32'h5);
    repeat (20) @(negedge clk);
    bus_write(4'h0, 32'h4);
    bus_write(4'h8, 32'h0000_0123);
    bus_read(4'h8, 32'h0, 32'hFFFF_FFFF, "R7 current cleared");
    bus_read(4'h0, 32'h0000_0004, 32'hFFFF_FFFF, "R7 flag cleared");

    // R8 reference mode with idle reference: no steps
    bus_write(4'h4, 32'd2);
    bus_write(4'h0, 32'h3);
    count_irq(40, pulses);
    check(pulses == 0, "R8 idle reference", pulses, 0);
    bus_read(4'h8, 32'h0, 32'hFFFF_FFFF, "R8 counter idle");

    // R8 reference rising edge every 8 clocks, reload 2 -> 24 clocks
    ref_run = 1;
    measure(0, gap);
    check(gap == 24, "R8 reference period", gap, 24);
    ref_run = 0;

    // R9 no-reference instance
    bus_write2(4'h0, 32'h3);
    bus_read2(4'h0, v);
    check((v & 32'h7) == 32'h7, "R9 clksource forced", int'(v & 32'h7), 7);
    bus_write2(4'h4, 32'd3);
    measure(1, gap);
    check(gap == 4, "R9 counts processor clock", gap, 4);
    bus_read2(4'hC, v);
    check(v == 32'h8000_0000, "R10 calib no-ref", int'(v >> 28), 8);

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R1 scoreboard drained", sb.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule